// File: doc/BRIEF.md
# Three-Level Auxiliary Table Walker

This block turns a 48-bit main-surface virtual address into the address of its auxiliary (compression) data, together with the format attributes that go with that data. The mapping lives in memory as a three-level tree of 64-bit entries. A lookup request carries the virtual address and the byte address of the top table. The walker then fetches one entry per level through a single-beat read port until it reaches the leaf.

Each level is indexed by a different slice of the address: 12 bits, then 12 bits, then 8 bits. The lowest 16 address bits never take part in the walk. The top and middle entries hold the base of the next table, aligned to 32 KiB and 8 KiB respectively. That base is made canonical (upper bits copied from bit 47) before it is used.

A leaf entry with its valid flag set gives a hit. The walker returns the 256-byte-aligned aux address and the decoded format, plane, depth and tiling fields. A clear valid flag at any level ends the walk at once and gives a miss tagged with the level that failed.

Top module: `auxw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_rd_valid` and `res_valid` are 0.
- R2: The first read of a walk goes to `req_base + 8*addr[47:36]`.
- R3: The second read goes to `C + 8*addr[35:24]`. Here C is the top entry with bits 14:0 and 63:48 cleared, then sign-extended from bit 47 into bits 63:48.
- R4: The third read goes to `C + 8*addr[23:16]`. Here C is the middle entry with bits 12:0 and 63:48 cleared, then sign-extended from bit 47.
- R5: Address bits 15:0 have no effect on any read address or on the result.
- R6: An entry whose bit 0 is 0 ends the walk. No further read is issued. The block reports `res_hit`=0 with `res_miss_level` set to 0 (top), 1 (middle) or 2 (leaf), and all result fields zero.
- R7: On a hit, `res_aux_addr` equals leaf bits 47:8 followed by eight zero bits.
- R8: On a hit, the format code is leaf bits 63:58, the plane flag is bit 57, the depth code is bits 56:54 and the tile code is bits 53:52.
- R9: On a hit, `res_bpp` decodes the depth code as follows: 0→16, 1→10, 2→12, 3→0, 4→8, 5→32, 6→64, 7→128.
- R10: On a hit, `res_tile_rsvd` is 1 exactly when the tile code is 2 or 3. Code 0 is Ys tiling and code 1 is Y tiling.
- R11: At most one read is in flight at a time. `mem_rd_valid` holds with a stable address until `mem_rd_ready`. `req_ready` is 1 only while no walk is in progress.
- R12: Each accepted request produces exactly one single-cycle `res_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle, request taken |
| req_addr | input | 48 | Main-surface virtual address |
| req_base | input | 64 | Byte address of the top table |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 64 | Byte address of the entry to fetch |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker waiting for read data |
| mem_rsp_data | input | 64 | Fetched 64-bit entry |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | 1 = translation found |
| res_miss_level | output | 2 | Level whose entry was invalid |
| res_aux_addr | output | 48 | Auxiliary data address |
| res_format | output | 6 | Format code |
| res_ycr | output | 1 | Plane flag (Y/Cr) |
| res_depth | output | 3 | Raw depth code |
| res_tile | output | 2 | Tile mode code |
| res_tile_rsvd | output | 1 | Tile code is reserved |
| res_bpp | output | 8 | Bits per pixel decoded from depth |

## Verification
The bench stores entries whose unused bits are filled with noise. A walker that masked the next-table base at the wrong boundary, or forgot to clear bits 63:48, would then fetch from the wrong address. Next-table bases with bit 47 set test the sign extension: a zero-extending design reads from a non-canonical address. Invalid entries that still carry nonzero bits are placed at each level; a design that checks anything but bit 0, or that goes on fetching, shows a wrong level code or an extra read. Every depth and tile code is run through a leaf, and the read port is stalled at random to catch an address that moves before the read is accepted.

// File: rtl/auxw_pkg.sv
package auxw_pkg;
  parameter int VA_W         = 48;
  parameter int ENTRY_W      = 64;
  parameter int ENTRY_SHIFT  = 3;
  parameter int TOP_IDX_LSB  = 36;
  parameter int TOP_IDX_W    = 12;
  parameter int MID_IDX_LSB  = 24;
  parameter int MID_IDX_W    = 12;
  parameter int LEAF_IDX_LSB = 16;
  parameter int LEAF_IDX_W   = 8;
  parameter int TOP_ALIGN    = 15;
  parameter int MID_ALIGN    = 13;
  parameter int AUX_ALIGN    = 8;
  parameter int VALID_BIT    = 0;
  parameter int FMT_LSB      = 58;
  parameter int FMT_W        = 6;
  parameter int YCR_BIT      = 57;
  parameter int DEPTH_LSB    = 54;
  parameter int DEPTH_W      = 3;
  parameter int TILE_LSB     = 52;
  parameter int TILE_W       = 2;
  parameter int BPP_W        = 8;

  localparam int IDX_W0 = (TOP_IDX_W > MID_IDX_W) ? TOP_IDX_W : MID_IDX_W;
  localparam int IDX_W  = (IDX_W0 > LEAF_IDX_W) ? IDX_W0 : LEAF_IDX_W;

  typedef enum logic [1:0] {LVL_TOP = 2'd0, LVL_MID = 2'd1, LVL_LEAF = 2'd2} lvl_e;

  typedef struct packed {
    logic [FMT_W-1:0]   fmt;
    logic               ycr;
    logic [DEPTH_W-1:0] depth;
    logic [TILE_W-1:0]  tile;
    logic               tile_rsvd;
    logic [BPP_W-1:0]   bpp;
    logic [VA_W-1:0]    aux_addr;
  } leaf_info_t;

  // Copy the top virtual-address bit into every bit above it.
  function automatic logic [ENTRY_W-1:0] canon(input logic [ENTRY_W-1:0] a);
    return {{(ENTRY_W-VA_W){a[VA_W-1]}}, a[VA_W-1:0]};
  endfunction

  // Base of the table one level down, taken from a valid entry.
  function automatic logic [ENTRY_W-1:0] next_base(input lvl_e l, input logic [ENTRY_W-1:0] e);
    logic [ENTRY_W-1:0] keep;
    keep = {ENTRY_W{1'b1}} << ((l == LVL_TOP) ? TOP_ALIGN : MID_ALIGN);
    return canon(e & keep);
  endfunction

  function automatic logic [IDX_W-1:0] index_of(input lvl_e l, input logic [VA_W-1:0] va);
    case (l)
      LVL_TOP: return IDX_W'(va[TOP_IDX_LSB +: TOP_IDX_W]);
      LVL_MID: return IDX_W'(va[MID_IDX_LSB +: MID_IDX_W]);
      default: return IDX_W'(va[LEAF_IDX_LSB +: LEAF_IDX_W]);
    endcase
  endfunction

  function automatic logic [BPP_W-1:0] bpp_of(input logic [DEPTH_W-1:0] code);
    case (code)
      3'd0: return BPP_W'(16);
      3'd1: return BPP_W'(10);
      3'd2: return BPP_W'(12);
      3'd4: return BPP_W'(8);
      3'd5: return BPP_W'(32);
      3'd6: return BPP_W'(64);
      3'd7: return BPP_W'(128);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/auxw_entry_addr.sv
module auxw_entry_addr
  import auxw_pkg::*;
(
  input  lvl_e                lvl,
  input  logic [ENTRY_W-1:0]  tbase,
  input  logic [VA_W-1:0]     va,
  output logic [ENTRY_W-1:0]  eaddr
);
  logic [IDX_W-1:0] idx;

  assign idx   = index_of(lvl, va);
  assign eaddr = tbase + (ENTRY_W'(idx) << ENTRY_SHIFT);
endmodule

// File: rtl/auxw_leaf_dec.sv
module auxw_leaf_dec
  import auxw_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  output leaf_info_t         info
);
  logic unused_leaf_bits;

  assign unused_leaf_bits = ^{entry[TILE_LSB-1:VA_W], entry[AUX_ALIGN-1:0]};

  always_comb begin
    info.fmt       = entry[FMT_LSB +: FMT_W];
    info.ycr       = entry[YCR_BIT];
    info.depth     = entry[DEPTH_LSB +: DEPTH_W];
    info.tile      = entry[TILE_LSB +: TILE_W];
    info.tile_rsvd = entry[TILE_LSB + TILE_W - 1];
    info.bpp       = bpp_of(entry[DEPTH_LSB +: DEPTH_W]);
    info.aux_addr  = {entry[VA_W-1:AUX_ALIGN], {AUX_ALIGN{1'b0}}};
  end
endmodule

// File: rtl/auxw_walker.sv
module auxw_walker
  import auxw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_addr,
  input  logic [ENTRY_W-1:0] req_base,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [ENTRY_W-1:0] mem_rd_addr,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               res_valid,
  output logic               res_hit,
  output logic [1:0]         res_miss_level,
  output logic [VA_W-1:0]    res_aux_addr,
  output logic [FMT_W-1:0]   res_format,
  output logic               res_ycr,
  output logic [DEPTH_W-1:0] res_depth,
  output logic [TILE_W-1:0]  res_tile,
  output logic               res_tile_rsvd,
  output logic [BPP_W-1:0]   res_bpp
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

  st_e                st;
  lvl_e               lvl;
  logic [VA_W-1:0]    va_q;
  logic [ENTRY_W-1:0] tbase_q;
  logic [ENTRY_W-1:0] entry_addr;
  leaf_info_t         leaf;

  // Named internal events, used by the bound checker.
  logic req_fire, rd_fire, rsp_fire, entry_ok, walk_miss, walk_hit, walk_step;

  assign req_ready     = (st == ST_IDLE);
  assign mem_rd_valid  = (st == ST_ISSUE);
  assign mem_rsp_ready = (st == ST_WAIT);
  assign mem_rd_addr   = entry_addr;

  assign req_fire  = req_valid && req_ready;
  assign rd_fire   = mem_rd_valid && mem_rd_ready;
  assign rsp_fire  = mem_rsp_valid && mem_rsp_ready;
  assign entry_ok  = mem_rsp_data[VALID_BIT];
  assign walk_miss = rsp_fire && !entry_ok;
  assign walk_hit  = rsp_fire && entry_ok && (lvl == LVL_LEAF);
  assign walk_step = rsp_fire && entry_ok && (lvl != LVL_LEAF);

  auxw_entry_addr u_addr (
    .lvl   (lvl),
    .tbase (tbase_q),
    .va    (va_q),
    .eaddr (entry_addr)
  );

  auxw_leaf_dec u_leaf (
    .entry (mem_rsp_data),
    .info  (leaf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st             <= ST_IDLE;
      lvl            <= LVL_TOP;
      va_q           <= '0;
      tbase_q        <= '0;
      res_valid      <= 1'b0;
      res_hit        <= 1'b0;
      res_miss_level <= '0;
      res_aux_addr   <= '0;
      res_format     <= '0;
      res_ycr        <= 1'b0;
      res_depth      <= '0;
      res_tile       <= '0;
      res_tile_rsvd  <= 1'b0;
      res_bpp        <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_fire) begin
            va_q    <= req_addr;
            tbase_q <= req_base;
            lvl     <= LVL_TOP;
            st      <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (rd_fire) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (walk_step) begin
            tbase_q <= next_base(lvl, mem_rsp_data);
            lvl     <= lvl_e'(lvl + 2'd1);
            st      <= ST_ISSUE;
          end else if (walk_miss || walk_hit) begin
            st             <= ST_IDLE;
            res_valid      <= 1'b1;
            res_hit        <= walk_hit;
            res_miss_level <= walk_hit ? 2'd0 : lvl;
            res_aux_addr   <= walk_hit ? leaf.aux_addr : '0;
            res_format     <= walk_hit ? leaf.fmt : '0;
            res_ycr        <= walk_hit && leaf.ycr;
            res_depth      <= walk_hit ? leaf.depth : '0;
            res_tile       <= walk_hit ? leaf.tile : '0;
            res_tile_rsvd  <= walk_hit && leaf.tile_rsvd;
            res_bpp        <= walk_hit ? leaf.bpp : '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/auxw_walker_chk.sv
module auxw_walker_chk
  import auxw_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               req_fire,
  input logic [VA_W-1:0]    req_addr,
  input logic [ENTRY_W-1:0] req_base,
  input logic               mem_rd_valid,
  input logic               mem_rd_ready,
  input logic [ENTRY_W-1:0] mem_rd_addr,
  input logic               mem_rsp_ready,
  input logic [ENTRY_W-1:0] mem_rsp_data,
  input logic               walk_miss,
  input logic               walk_hit,
  input logic               res_valid,
  input logic               res_hit,
  input logic [1:0]         res_miss_level,
  input logic [VA_W-1:0]    res_aux_addr,
  input logic [TILE_W-1:0]  res_tile,
  input logic               res_tile_rsvd
);
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_valid && !mem_rsp_ready);

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> mem_rd_valid &&
      mem_rd_addr == $past(req_base) + (ENTRY_W'($past(req_addr[TOP_IDX_LSB +: TOP_IDX_W])) << 3));

  assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_miss_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_miss_level != 2'd3 && res_aux_addr == '0);

  assert_miss_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    walk_miss |=> !mem_rd_valid && res_valid && !res_hit);

  assert_hit_aux_R7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_hit |=> res_valid && res_hit &&
      res_aux_addr == {$past(mem_rsp_data[VA_W-1:AUX_ALIGN]), {AUX_ALIGN{1'b0}}});

  assert_tile_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit |-> res_tile_rsvd == (res_tile >= 2'd2));
endmodule

bind auxw_walker auxw_walker_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_ready      (req_ready),
  .req_fire       (req_fire),
  .req_addr       (req_addr),
  .req_base       (req_base),
  .mem_rd_valid   (mem_rd_valid),
  .mem_rd_ready   (mem_rd_ready),
  .mem_rd_addr    (mem_rd_addr),
  .mem_rsp_ready  (mem_rsp_ready),
  .mem_rsp_data   (mem_rsp_data),
  .walk_miss      (walk_miss),
  .walk_hit       (walk_hit),
  .res_valid      (res_valid),
  .res_hit        (res_hit),
  .res_miss_level (res_miss_level),
  .res_aux_addr   (res_aux_addr),
  .res_tile       (res_tile),
  .res_tile_rsvd  (res_tile_rsvd)
);

// File: tb/tb_auxw_walker.sv
`timescale 1ns/1ps
module tb_auxw_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [47:0] req_addr = '0;
  logic [63:0] req_base = '0;
  logic        mem_rd_valid, mem_rd_ready = 1'b0;
  logic [63:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid, res_hit, res_ycr, res_tile_rsvd;
  logic [1:0]  res_miss_level, res_tile;
  logic [47:0] res_aux_addr;
  logic [5:0]  res_format;
  logic [2:0]  res_depth;
  logic [7:0]  res_bpp;

  auxw_walker dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_base(req_base),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss_level(res_miss_level),
    .res_aux_addr(res_aux_addr), .res_format(res_format), .res_ycr(res_ycr),
    .res_depth(res_depth), .res_tile(res_tile), .res_tile_rsvd(res_tile_rsvd), .res_bpp(res_bpp)
  );

  logic [63:0] mem [logic [63:0]];
  int n_chk = 0;
  int n_err = 0;

  // memory model state
  bit          pend = 0, fire_q = 0, rsp_rdy_q = 0, hold_q = 0;
  logic [63:0] pend_addr = '0, fire_addr = '0, hold_addr = '0;
  int          pend_wait = 0, stab_err = 0, rd_cnt = 0, res_cnt = 0;
  logic [63:0] rd_log [4];
  bit          c_hit, c_ycr, c_rsvd;
  logic [1:0]  c_lvl, c_tile;
  logic [47:0] c_aux;
  logic [5:0]  c_fmt;
  logic [2:0]  c_depth;
  logic [7:0]  c_bpp;

  task automatic chk_eq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd_mem(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h0;
  endfunction

  function automatic logic [63:0] sext47(input logic [63:0] x);
    return x[47] ? (x | 64'hFFFF_0000_0000_0000) : (x & 64'h0000_FFFF_FFFF_FFFF);
  endfunction

  function automatic logic [63:0] slot(input logic [63:0] base, input logic [63:0] idx);
    return base + idx * 64'd8;
  endfunction

  function automatic logic [7:0] want_bpp(input logic [2:0] c);
    logic [7:0] t;
    if (c == 3'd4) t = 8'd8;
    else if (c == 3'd1) t = 8'd10;
    else if (c == 3'd2) t = 8'd12;
    else if (c == 3'd0) t = 8'd16;
    else if (c == 3'd5) t = 8'd32;
    else if (c == 3'd6) t = 8'd64;
    else if (c == 3'd7) t = 8'd128;
    else t = 8'd0;
    return t;
  endfunction

  // Addresses of the three levels from entries already in memory.
  function automatic logic [63:0] mid_slot(input logic [47:0] va, input logic [63:0] e0);
    return slot(sext47(e0 & 64'h0000_FFFF_FFFF_8000), 64'(va[35:24]));
  endfunction
  function automatic logic [63:0] leaf_slot(input logic [47:0] va, input logic [63:0] e1);
    return slot(sext47(e1 & 64'h0000_FFFF_FFFF_E000), 64'(va[23:16]));
  endfunction

  task automatic put_path(input logic [47:0] va, input logic [63:0] base,
                          input bit v0, input bit v1, input bit v2,
                          input logic [63:0] r0, input logic [63:0] r1, input logic [63:0] r2);
    logic [63:0] a0, a1, a2, e0, e1;
    a0 = slot(base, 64'(va[47:36]));
    e0 = {r0[63:1], v0};
    mem[a0] = e0;
    a1 = mid_slot(va, e0);
    e1 = {r1[63:1], v1};
    mem[a1] = e1;
    a2 = leaf_slot(va, e1);
    mem[a2] = {r2[63:1], v2};
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0;
      pend = 0; fire_q = 0; rsp_rdy_q = 0; hold_q = 0;
    end else begin
      if (hold_q && (!mem_rd_valid || mem_rd_addr !== hold_addr)) stab_err++;
      if (fire_q) begin
        pend = 1; pend_addr = fire_addr; pend_wait = int'($urandom % 3);
        if (rd_cnt < 4) rd_log[rd_cnt] = fire_addr;
        rd_cnt++;
      end
      if (mem_rsp_valid && rsp_rdy_q) mem_rsp_valid = 1'b0;
      if (pend && !mem_rsp_valid) begin
        if (pend_wait == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = rd_mem(pend_addr); pend = 0;
        end else pend_wait--;
      end
      mem_rd_ready = !pend && !mem_rsp_valid && (($urandom % 4) != 0);
      fire_q    = mem_rd_valid && mem_rd_ready;
      fire_addr = mem_rd_addr;
      hold_q    = mem_rd_valid && !mem_rd_ready;
      hold_addr = mem_rd_addr;
      rsp_rdy_q = mem_rsp_ready;
      if (res_valid) begin
        res_cnt++;
        c_hit = res_hit; c_lvl = res_miss_level; c_aux = res_aux_addr; c_fmt = res_format;
        c_ycr = res_ycr; c_depth = res_depth; c_tile = res_tile; c_rsvd = res_tile_rsvd; c_bpp = res_bpp;
      end
    end
  end

  task automatic lookup(input logic [47:0] va, input logic [63:0] base, input string tag);
    logic [63:0] a0, a1, a2, e0, e1, e2;
    bit          x_hit;
    logic [1:0]  x_lvl;
    int          x_n, guard;
    a0 = slot(base, 64'(va[47:36])); e0 = rd_mem(a0);
    a1 = mid_slot(va, e0);           e1 = rd_mem(a1);
    a2 = leaf_slot(va, e1);          e2 = rd_mem(a2);
    if (!e0[0])      begin x_n = 1; x_hit = 0; x_lvl = 2'd0; end
    else if (!e1[0]) begin x_n = 2; x_hit = 0; x_lvl = 2'd1; end
    else if (!e2[0]) begin x_n = 3; x_hit = 0; x_lvl = 2'd2; end
    else             begin x_n = 3; x_hit = 1; x_lvl = 2'd0; end

    @(negedge clk);
    guard = 0;
    while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
    rd_cnt = 0; res_cnt = 0;
    req_valid = 1'b1; req_addr = va; req_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    chk_eq("R11", {tag, " busy after accept"}, 64'(req_ready), 64'd0);
    guard = 0;
    while (res_cnt == 0 && guard < 200) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    chk_eq("R12", {tag, " result pulses"}, 64'(res_cnt), 64'd1);
    chk_eq("R6", {tag, " read count"}, 64'(rd_cnt), 64'(x_n));
    chk_eq("R2", {tag, " top read addr"}, rd_log[0], a0);
    if (x_n >= 2) chk_eq("R3", {tag, " mid read addr"}, rd_log[1], a1);
    if (x_n >= 3) chk_eq("R4", {tag, " leaf read addr"}, rd_log[2], a2);
    chk_eq("R6", {tag, " hit flag"}, 64'(c_hit), 64'(x_hit));
    if (x_hit) begin
      chk_eq("R7", {tag, " aux addr"}, 64'(c_aux), e2 & 64'h0000_FFFF_FFFF_FF00);
      chk_eq("R8", {tag, " fields"}, {c_fmt, c_ycr, c_depth, c_tile},
             64'({e2[63:58], e2[57], e2[56:54], e2[53:52]}));
      chk_eq("R9", {tag, " bpp"}, 64'(c_bpp), 64'(want_bpp(e2[56:54])));
      chk_eq("R10", {tag, " tile reserved"}, 64'(c_rsvd), 64'(e2[53]));
    end else begin
      chk_eq("R6", {tag, " miss level"}, 64'(c_lvl), 64'(x_lvl));
      chk_eq("R6", {tag, " miss fields zero"},
             64'({c_aux, c_fmt, c_ycr, c_depth, c_tile, c_rsvd}) | 64'(c_bpp), 64'd0);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [47:0] va, va_b;
    logic [63:0] base;
    logic [47:0] aux_a;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk_eq("R1", "req_ready", 64'(req_ready), 64'd1);
    chk_eq("R1", "mem_rd_valid", 64'(mem_rd_valid), 64'd0);
    chk_eq("R1", "res_valid", 64'(res_valid), 64'd0);

    // R8 R9 R10: every depth and tile code, maximal indices
    base = 64'h0000_0000_0040_0000;
    va   = 48'hFFF_FFF_FF_1234;
    for (int d = 0; d < 8; d++) begin
      put_path(va, base, 1, 1, 1, 64'h5A5A_0000_0080_7FFE, 64'h3C3C_0000_00A0_1FFE,
               {6'(d * 9 + 1), 1'(d), 3'(d), 2'(d % 4), 4'hB, 40'h12_3456_78AB + 40'(d), 7'h55, 1'b1});
      lookup(va, base, "depth/tile sweep");
    end

    // R3 R4: next-table bases with bit 47 set need sign extension
    base = 64'h0000_0000_0100_0000;
    va   = 48'h001_002_03_0000;
    put_path(va, base, 1, 1, 1, 64'h0000_8123_4567_8000, 64'h0000_F00D_CAFE_2000,
             64'hFC00_0000_0000_0001 | 64'h0000_7654_3210_0000);
    lookup(va, base, "canonical bases");

    // R5: low 16 bits of the address do not matter
    va_b = va | 48'h0000_0000_BEEF;
    lookup(va, base, "low bits clear");
    aux_a = c_aux;
    lookup(va_b, base, "low bits set");
    chk_eq("R5", "aux addr independent of low bits", 64'(c_aux), 64'(aux_a));
    chk_eq("R5", "second read ignores low bits", rd_log[1], mid_slot(va_b, rd_mem(slot(base, 64'(va[47:36])))));

    // R6: miss at each level with noisy entries
    base = 64'h0000_0000_0200_0000;
    va   = 48'h7A0_155_2B_0000;
    put_path(va, base, 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 64'h1);
    lookup(va, base, "miss top");
    put_path(va, base, 1, 0, 1, 64'h0000_0000_0300_0000, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1);
    lookup(va, base, "miss mid");
    put_path(va, base, 1, 1, 0, 64'h0000_0000_0300_0000, 64'h0000_0000_0400_0000, 64'hFFFF_FFFF_FFFF_FFFE);
    lookup(va, base, "miss leaf");
    // index zero everywhere
    va = 48'h000_000_00_FFFF;
    put_path(va, base, 1, 1, 1, 64'h0000_0000_0500_0000, 64'h0000_0000_0600_0000, 64'h8000_0000_0000_0101);
    lookup(va, base, "zero indices");

    // random mix
    for (int i = 0; i < 300; i++) begin
      base = {$urandom, $urandom};
      va   = 48'({$urandom, $urandom});
      put_path(va, base, ($urandom % 6) != 0, ($urandom % 6) != 0, ($urandom % 6) != 0,
               {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
      lookup(va, base, "random");
    end

    chk_eq("R11", "read address held while stalled", 64'(stab_err), 64'd0);
    finish_run();
  end
endmodule